// File: doc/BRIEF.md
# Chaining DMA Descriptor Engine

This block sequences a chain of memory moves for one transfer direction. Software launches a chain with a single header write that carries a descriptor count and the byte address of the first descriptor. The engine then walks a contiguous table in host memory. It reads each 16-byte descriptor through a simple read request/response port. From each descriptor it issues one move command carrying the length, source and destination, and it waits for the mover to report that the last data beat of that move has been transferred before it fetches the next descriptor.

Status outputs tell software when the engine is busy and when a chain has completed. A sticky flag records a header write that arrived while a chain was running. An optional per-descriptor interrupt pulse is enabled by a control bit in the descriptor itself. A saturating cycle counter measures the whole chain, starting from the header write. It therefore includes the latency of the first descriptor fetch, and software can divide bytes moved by this count to obtain throughput. A read-direction instance and a write-direction instance can run side by side, with an external arbiter merging their request ports.

Top module: `dma_chain_engine`

## Requirements
- R1: A header write (`hdr_wr`) accepted while idle with a nonzero count raises `busy` at the next clock edge and clears `done` and `err`. The first read request then carries `hdr_addr`.
- R2: Descriptor k of a chain is read from `hdr_addr + 16*k` using exactly one request. `rd_req_valid` and `rd_req_addr` hold until `rd_req_ready`. The four response words are taken in arrival order as word 0 = length, word 1 = source, word 2 = destination and word 3 = control.
- R3: Each descriptor produces one move command whose `mv_len`, `mv_src` and `mv_dst` equal its words 0, 1 and 2. The command is held stable until `mv_ready`.
- R4: No descriptor read is issued while a move is outstanding; the next fetch starts only after `mv_done`. After `mv_done` of the last descriptor, `busy` falls and `done` rises at the same edge, and exactly `count` reads and moves have taken place.
- R5: An accepted header with count zero sets `done` at the next edge. `busy` never rises and no read request is made.
- R6: A header write while `busy` is ignored: the running chain keeps its original count and addresses. The write sets `err`, which stays set until the next accepted header.
- R7: When bit 0 of a descriptor's control word is 1, `irq` pulses high for one cycle at the edge that samples that descriptor's `mv_done`. When that bit is 0, no pulse occurs.
- R8: `perf_count` is cleared by an accepted header. It then increments once per clock edge up to and including the edge that samples the final `mv_done`, and holds that value while idle.
- R9: `perf_count` stops at its maximum value 2^PERF_W-1 instead of wrapping.
- R10: Response beats that arrive with no descriptor read outstanding, and `mv_done` pulses outside a move, are ignored: no state, status or `irq` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_wr | input | 1 | Header write strobe |
| hdr_count | input | CW | Number of descriptors in the chain |
| hdr_addr | input | AW | Byte address of the first descriptor |
| busy | output | 1 | Chain in progress |
| done | output | 1 | Last chain completed |
| err | output | 1 | Header written while busy (sticky) |
| perf_count | output | PERF_W | Saturating chain cycle count |
| rd_req_valid | output | 1 | Descriptor read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Descriptor byte address |
| rd_rsp_valid | input | 1 | Response word valid |
| rd_rsp_data | input | 32 | Response word |
| mv_valid | output | 1 | Move command valid |
| mv_ready | input | 1 | Move command accepted |
| mv_len | output | 32 | Move length in bytes |
| mv_src | output | 32 | Move source address |
| mv_dst | output | 32 | Move destination address |
| mv_done | input | 1 | Last beat of current move transferred |
| irq | output | 1 | Per-descriptor completion pulse |

## Verification
The bench builds the engine with AW=32, CW=8 and PERF_W=8. The narrow counter makes saturation reachable with a single slowed move of about 300 cycles. The 8-bit count keeps random chains short while still covering several back-to-back fetches. A table base near 0xFFF0 pushes the 16-byte address step across a 16-bit carry. Random request, response and move latencies move every handshake to different cycles, so the per-edge counter value is checked against timing that varies from chain to chain.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned DESC_WORDS  = 4;
  localparam int unsigned DESC_BYTES  = DESC_WORDS * WORD_W / 8;
  localparam int unsigned CTL_IRQ_BIT = 0;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_FETCH,
    SEQ_ISSUE,
    SEQ_MOVE
  } seq_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] len;
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] dst;
    logic              irq_en;
  } desc_t;
endpackage

// File: rtl/dce_fetch.sv
module dce_fetch
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              desc_valid,
  output desc_t             desc
);
  localparam int unsigned BW = $clog2(DESC_WORDS);

  logic                  pend_q, pend_d;
  logic                  coll_q, coll_d;
  logic                  dv_q, dv_d;
  logic [BW-1:0]         beat_q, beat_d;
  logic [AW-1:0]         addr_q, addr_d;
  logic [DESC_WORDS-1:0] word_en;
  logic                  ctl_en;
  desc_t                 desc_q;

  always_comb begin
    pend_d  = pend_q;
    coll_d  = coll_q;
    beat_d  = beat_q;
    addr_d  = addr_q;
    dv_d    = 1'b0;
    word_en = '0;
    if (start) begin
      pend_d = 1'b1;
      addr_d = base;
    end
    if (pend_q && req_ready) begin
      pend_d = 1'b0;
      coll_d = 1'b1;
      beat_d = '0;
    end
    for (int i = 0; i < int'(DESC_WORDS); i++) begin
      if (coll_q && rsp_valid && beat_q == BW'(i)) word_en[i] = 1'b1;
    end
    if (coll_q && rsp_valid) begin
      beat_d = beat_q + 1'b1;
      if (beat_q == BW'(DESC_WORDS - 1)) begin
        coll_d = 1'b0;
        dv_d   = 1'b1;
      end
    end
  end

  assign ctl_en = word_en[DESC_WORDS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      coll_q <= 1'b0;
      dv_q   <= 1'b0;
      beat_q <= '0;
      addr_q <= '0;
    end else begin
      pend_q <= pend_d;
      coll_q <= coll_d;
      dv_q   <= dv_d;
      beat_q <= beat_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (word_en[0]) desc_q.len    <= rsp_data;
    if (word_en[1]) desc_q.src    <= rsp_data;
    if (word_en[2]) desc_q.dst    <= rsp_data;
    if (ctl_en)     desc_q.irq_en <= rsp_data[CTL_IRQ_BIT];
  end

  assign req_valid  = pend_q;
  assign req_addr   = addr_q;
  assign desc_valid = dv_q;
  assign desc       = desc_q;
endmodule

// File: rtl/dce_perf.sv
module dce_perf #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         run,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] CMAX = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clear | (run & (cnt_q != CMAX));
    cnt_d  = clear ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/dce_seq.sv
module dce_seq
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_wr,
  input  logic [CW-1:0]     hdr_count,
  input  logic [AW-1:0]     hdr_addr,
  output logic              fetch_start,
  output logic [AW-1:0]     fetch_addr,
  input  logic              desc_valid,
  input  desc_t             desc,
  output logic              mv_valid,
  input  logic              mv_ready,
  output logic [WORD_W-1:0] mv_len,
  output logic [WORD_W-1:0] mv_src,
  output logic [WORD_W-1:0] mv_dst,
  input  logic              mv_done,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              irq,
  output logic              perf_clear,
  output logic              perf_run
);
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  seq_state_e    st_q, st_d;
  logic [CW-1:0] rem_q, rem_d;
  logic [AW-1:0] nxt_q, nxt_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          irq_q, irq_d;
  logic          accept;
  logic          cmd_en;
  desc_t         cmd_q;

  assign accept = hdr_wr && (st_q == SEQ_IDLE);
  assign cmd_en = (st_q == SEQ_FETCH) && desc_valid;

  always_comb begin
    st_d        = st_q;
    rem_d       = rem_q;
    nxt_d       = nxt_q;
    done_d      = done_q;
    err_d       = err_q;
    irq_d       = 1'b0;
    fetch_start = 1'b0;
    fetch_addr  = nxt_q;
    if (hdr_wr && st_q != SEQ_IDLE) err_d = 1'b1;
    case (st_q)
      SEQ_IDLE: begin
        if (accept) begin
          err_d  = 1'b0;
          done_d = (hdr_count == '0);
          if (hdr_count != '0) begin
            st_d        = SEQ_FETCH;
            rem_d       = hdr_count;
            fetch_start = 1'b1;
            fetch_addr  = hdr_addr;
            nxt_d       = hdr_addr + STEP;
          end
        end
      end
      SEQ_FETCH: begin
        if (desc_valid) st_d = SEQ_ISSUE;
      end
      SEQ_ISSUE: begin
        if (mv_ready) st_d = SEQ_MOVE;
      end
      SEQ_MOVE: begin
        if (mv_done) begin
          irq_d = cmd_q.irq_en;
          rem_d = rem_q - 1'b1;
          if (rem_q == CW'(1)) begin
            st_d   = SEQ_IDLE;
            done_d = 1'b1;
          end else begin
            st_d        = SEQ_FETCH;
            fetch_start = 1'b1;
            fetch_addr  = nxt_q;
            nxt_d       = nxt_q + STEP;
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      rem_q  <= '0;
      nxt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      nxt_q  <= nxt_d;
      done_q <= done_d;
      err_q  <= err_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd_en) cmd_q <= desc;
  end

  assign mv_valid   = (st_q == SEQ_ISSUE);
  assign mv_len     = cmd_q.len;
  assign mv_src     = cmd_q.src;
  assign mv_dst     = cmd_q.dst;
  assign busy       = (st_q != SEQ_IDLE);
  assign done       = done_q;
  assign err        = err_q;
  assign irq        = irq_q;
  assign perf_clear = accept;
  assign perf_run   = busy;
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned CW     = 16,
  parameter int unsigned PERF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_wr,
  input  logic [CW-1:0]     hdr_count,
  input  logic [AW-1:0]     hdr_addr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [PERF_W-1:0] perf_count,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [AW-1:0]     rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [WORD_W-1:0] rd_rsp_data,
  output logic              mv_valid,
  input  logic              mv_ready,
  output logic [WORD_W-1:0] mv_len,
  output logic [WORD_W-1:0] mv_src,
  output logic [WORD_W-1:0] mv_dst,
  input  logic              mv_done,
  output logic              irq
);
  logic          fetch_start;
  logic [AW-1:0] fetch_addr;
  logic          desc_valid;
  desc_t         desc;
  logic          perf_clear;
  logic          perf_run;

  dce_fetch #(.AW(AW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fetch_start),
    .base       (fetch_addr),
    .req_valid  (rd_req_valid),
    .req_ready  (rd_req_ready),
    .req_addr   (rd_req_addr),
    .rsp_valid  (rd_rsp_valid),
    .rsp_data   (rd_rsp_data),
    .desc_valid (desc_valid),
    .desc       (desc)
  );

  dce_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_wr      (hdr_wr),
    .hdr_count   (hdr_count),
    .hdr_addr    (hdr_addr),
    .fetch_start (fetch_start),
    .fetch_addr  (fetch_addr),
    .desc_valid  (desc_valid),
    .desc        (desc),
    .mv_valid    (mv_valid),
    .mv_ready    (mv_ready),
    .mv_len      (mv_len),
    .mv_src      (mv_src),
    .mv_dst      (mv_dst),
    .mv_done     (mv_done),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .irq         (irq),
    .perf_clear  (perf_clear),
    .perf_run    (perf_run)
  );

  dce_perf #(.W(PERF_W)) u_perf (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (perf_clear),
    .run   (perf_run),
    .count (perf_count)
  );
endmodule

// File: rtl/dce_checker.sv
module dce_checker #(
  parameter int unsigned AW     = 32,
  parameter int unsigned CW     = 16,
  parameter int unsigned PERF_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hdr_wr,
  input logic [CW-1:0]     hdr_count,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [PERF_W-1:0] perf_count,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [AW-1:0]     rd_req_addr,
  input logic              mv_valid,
  input logic              mv_ready,
  input logic [31:0]       mv_len,
  input logic [31:0]       mv_src,
  input logic [31:0]       mv_dst,
  input logic              mv_done,
  input logic              irq
);
  localparam logic [PERF_W-1:0] PMAX = '1;

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_wr && !busy && hdr_count != '0 |=> busy && !done && !err);

  p_req_only_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> busy);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid && !mv_ready |=> mv_valid && $stable({mv_len, mv_src, mv_dst}));

  p_end_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_zero_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_wr && !busy && hdr_count == '0 |=> done && !busy && !rd_req_valid);

  p_busy_hdr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_wr && busy |=> err);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mv_done));

  p_perf_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !hdr_wr |=> $stable(perf_count));

  p_perf_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    perf_count == PMAX && !(hdr_wr && !busy) |=> perf_count == PMAX);
endmodule

bind dma_chain_engine dce_checker #(.AW(AW), .CW(CW), .PERF_W(PERF_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hdr_wr       (hdr_wr),
  .hdr_count    (hdr_count),
  .busy         (busy),
  .done         (done),
  .err          (err),
  .perf_count   (perf_count),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .mv_valid     (mv_valid),
  .mv_ready     (mv_ready),
  .mv_len       (mv_len),
  .mv_src       (mv_src),
  .mv_dst       (mv_dst),
  .mv_done      (mv_done),
  .irq          (irq)
);

// File: tb/dma_chain_engine_tb.sv
module dma_chain_engine_tb;
  localparam int AW = 32;
  localparam int CW = 8;
  localparam int PW = 8;
  localparam int PMAX = (1 << PW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hdr_wr;
  logic [CW-1:0] hdr_count;
  logic [AW-1:0] hdr_addr;
  logic          busy, done, err, irq;
  logic [PW-1:0] perf_count;
  logic          rd_req_valid, rd_req_ready;
  logic [AW-1:0] rd_req_addr;
  logic          rd_rsp_valid;
  logic [31:0]   rd_rsp_data;
  logic          mv_valid, mv_ready, mv_done;
  logic [31:0]   mv_len, mv_src, mv_dst;

  always #5 clk = ~clk;

  dma_chain_engine #(.AW(AW), .CW(CW), .PERF_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hdr_wr(hdr_wr), .hdr_count(hdr_count),
    .hdr_addr(hdr_addr), .busy(busy), .done(done), .err(err),
    .perf_count(perf_count), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_len(mv_len),
    .mv_src(mv_src), .mv_dst(mv_dst), .mv_done(mv_done), .irq(irq)
  );

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;
  logic [31:0] salt = 32'h1234_5678;
  logic [31:0] exp_base = '0;
  int          exp_count = 0;
  int          req_seen = 0;
  int          mv_seen = 0;
  bit          in_move = 1'b0;
  int unsigned cyc_hdr = 0;
  int unsigned cyc_last = 0;
  int          slow_extra = 0;
  int          stray_rsp_req = 0, stray_rsp_ack = 0;
  int          stray_done_req = 0, stray_done_ack = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ salt ^ {a[15:0], a[31:16]};
  endfunction

  // memory responder: one request -> four response words
  initial begin : responder
    logic [31:0] a;
    rd_req_ready = 1'b0;
    rd_rsp_valid = 1'b0;
    rd_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (stray_rsp_ack != stray_rsp_req) begin
        for (int k = 0; k < 5; k++) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = 32'hBAD0_0000 + k;
          @(negedge clk);
        end
        rd_rsp_valid = 1'b0;
        stray_rsp_ack++;
      end else if (rd_req_valid) begin
        rd_req_ready = ($urandom_range(0, 2) != 0);
        if (rd_req_ready) begin
          a = rd_req_addr;
          check("R4", "fetch during move", {63'd0, in_move}, 64'd0);
          check("R2", "descriptor address", a, exp_base + 32'(16 * req_seen));
          req_seen++;
          @(negedge clk);
          rd_req_ready = 1'b0;
          repeat ($urandom_range(0, 3)) @(negedge clk);
          for (int k = 0; k < 4; k++) begin
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = mem_word(a + 32'(4 * k));
            @(negedge clk);
            rd_rsp_valid = 1'b0;
            if ($urandom_range(0, 3) == 0) @(negedge clk);
          end
        end
      end
    end
  end

  // mover model: accepts commands, reports last beat
  initial begin : mover
    logic [31:0] da, ln;
    logic        ie;
    mv_ready = 1'b0;
    mv_done  = 1'b0;
    forever begin
      @(negedge clk);
      if (stray_done_ack != stray_done_req) begin
        mv_done = 1'b1;
        @(negedge clk);
        mv_done = 1'b0;
        check("R10", "irq on stray mv_done", {63'd0, irq}, 64'd0);
        stray_done_ack++;
      end else if (mv_valid) begin
        mv_ready = ($urandom_range(0, 2) != 0);
        if (mv_ready) begin
          da = exp_base + 32'(16 * mv_seen);
          check("R3", "mv_len", mv_len, mem_word(da));
          check("R3", "mv_src", mv_src, mem_word(da + 32'd4));
          check("R3", "mv_dst", mv_dst, mem_word(da + 32'd8));
          ln = mem_word(da + 32'd12);
          ie = ln[0];
          in_move = 1'b1;
          @(negedge clk);
          mv_ready = 1'b0;
          repeat (int'(mv_len % 5) + slow_extra) @(negedge clk);
          if (mv_seen + 1 == exp_count) cyc_last = cyc + 1;
          mv_done = 1'b1;
          in_move = 1'b0;
          @(negedge clk);
          mv_done = 1'b0;
          check("R7", "irq after move", {63'd0, irq}, {63'd0, ie});
          mv_seen++;
        end
      end
    end
  end

  task automatic start_chain(input logic [31:0] base, input int count);
    salt      = $urandom;
    exp_base  = base;
    exp_count = count;
    req_seen  = 0;
    mv_seen   = 0;
    @(negedge clk);
    hdr_wr    = 1'b1;
    hdr_count = CW'(count);
    hdr_addr  = base;
    cyc_hdr   = cyc + 1;
    @(negedge clk);
    hdr_wr = 1'b0;
    check("R1", "busy after header", {63'd0, busy}, {63'd0, count != 0});
    check("R6", "err cleared by accepted header", {63'd0, err}, 64'd0);
    check("R5", "done after header", {63'd0, done}, {63'd0, count == 0});
  endtask

  task automatic finish_chain();
    int unsigned exp_perf;
    while (busy) @(negedge clk);
    @(negedge clk);
    check("R4", "done at chain end", {63'd0, done}, 64'd1);
    check("R2", "request count", 64'(req_seen), 64'(exp_count));
    check("R4", "move count", 64'(mv_seen), 64'(exp_count));
    exp_perf = (cyc_last - cyc_hdr > PMAX) ? PMAX : cyc_last - cyc_hdr;
    check(exp_perf == PMAX ? "R9" : "R8", "perf_count", perf_count, 64'(exp_perf));
    repeat (3) @(negedge clk);
    check("R8", "perf holds idle", perf_count, 64'(exp_perf));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    hdr_wr = 1'b0;
    hdr_count = '0;
    hdr_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset busy", {63'd0, busy}, 64'd0);
    check("R4", "reset done", {63'd0, done}, 64'd0);
    check("R6", "reset err", {63'd0, err}, 64'd0);
    check("R8", "reset perf", perf_count, 64'd0);
    check("R2", "reset rd_req_valid", {63'd0, rd_req_valid}, 64'd0);
    check("R7", "reset irq", {63'd0, irq}, 64'd0);

    // directed: single descriptor, then carry across 16-bit boundary
    start_chain(32'h0000_1000, 1);
    finish_chain();
    start_chain(32'h0000_FFF0, 3);
    finish_chain();

    // R5: empty chain
    start_chain(32'h0000_2000, 0);
    check("R5", "perf on empty chain", perf_count, 64'd0);
    repeat (6) @(negedge clk);
    check("R5", "no fetch on empty chain", 64'(req_seen), 64'd0);
    check("R5", "busy stays low", {63'd0, busy}, 64'd0);

    // R6: header while busy is ignored
    start_chain(32'h0004_0000, 4);
    repeat (3) @(negedge clk);
    hdr_wr = 1'b1;
    hdr_count = CW'(1);
    hdr_addr = 32'h0BAD_0000;
    @(negedge clk);
    hdr_wr = 1'b0;
    check("R6", "err after busy header", {63'd0, err}, 64'd1);
    finish_chain();
    check("R6", "err sticky after chain", {63'd0, err}, 64'd1);

    // R10: stray response beats and stray mv_done while idle
    stray_rsp_req++;
    while (stray_rsp_ack != stray_rsp_req) @(negedge clk);
    stray_done_req++;
    while (stray_done_ack != stray_done_req) @(negedge clk);
    @(negedge clk);
    check("R10", "busy after strays", {63'd0, busy}, 64'd0);
    check("R10", "done after strays", {63'd0, done}, 64'd1);
    check("R10", "rd_req_valid after strays", {63'd0, rd_req_valid}, 64'd0);
    start_chain(32'h0008_0040, 2);
    finish_chain();

    // R9: slow move drives the counter to saturation
    slow_extra = 300;
    start_chain(32'h0010_0000, 1);
    finish_chain();
    check("R9", "perf saturated", perf_count, 64'(PMAX));
    slow_extra = 0;

    // random chains
    for (int n = 0; n < 8; n++) begin
      logic [31:0] b;
      b = $urandom & 32'hFFFF_FFF0;
      start_chain(b, $urandom_range(1, 6));
      finish_chain();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule